// File: doc/BRIEF.md
# SPI Control Slave with Register File and Coefficient Banks

This block is the configuration port of a signal-processing datapath. A host drives a four-wire serial link: a serial clock, an active-low select, a data line into the block and a data line out of it. Each transaction is a 32-bit frame, sent most significant bit first. The first 16 bits are a command word. The last 16 bits carry the data word. The command word says three things: whether this is a read or a write, whether the target is the control-register file or a coefficient bank, and the target address.

Writes are held back until the last bit of a complete frame has been received. The block then updates one control register or one coefficient entry. Reads fetch the addressed word once the command half is complete, and shift that word out during the data half. The control registers are exported as one flat vector. The coefficient banks have a second, combinational read port for the filters that use them.

All serial inputs are first resynchronised into the system clock domain, and the block works on edges detected there. The serial clock must therefore stay below roughly one sixth of the system clock.

Top module: `spi_ctrl_slave`

## Requirements
- R1: After reset, every control register reads zero, and both `miso_o` and `miso_oe_o` are low.
- R2: A frame is 32 serial clock rising edges, captured MSB first. Command bit 15 = 1 selects a read and 0 a write. Command bit 14 = 1 selects a coefficient bank and 0 the register file.
- R3: A register write stores the data word into the register at command bits 4:0. Command bits 13:5 have no effect on a register access. The store takes effect once the 32nd rising edge has been seen.
- R4: A read drives the addressed 16-bit word on `miso_o`, MSB first, during serial clock pulses 17 to 32. The output changes only after a falling serial clock edge, so the host samples it at the next rising edge.
- R5: A memory write stores the data word into bank command[9:8] at entry command[7:0]. Bank depths are 128, 128 and 64 entries for codes 0, 1 and 2.
- R6: A memory read returns the stored coefficient on `miso_o` in the data half of the frame.
- R7: A memory write with bank code 3, or with an entry index at or beyond its bank's depth, changes no entry. A read of such an address returns zero.
- R8: If the select rises before 32 rising edges, the frame is dropped and nothing is written.
- R9: `miso_o` is low while the select is high and during the command half of a frame. `miso_oe_o` is high only while the select is low.
- R10: `coef_data_o` returns the entry at (`coef_bank_i`, `coef_addr_i`) combinationally, and zero for an unused bank code or an out-of-range entry.
- R11: Serial clock edges after the 32nd are ignored until the select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for the pad driver of `miso_o` |
| coef_bank_i | input | 2 | Bank code for the filter read port |
| coef_addr_i | input | 8 | Entry index for the filter read port |
| coef_data_o | output | 16 | Coefficient read by the filter port |
| regs_o | output | NUM_REGS*16 | All control registers; register n is bits n*16+15 to n*16 |

## Verification
Every control register is written with a value derived from its index, then read back both over the serial link and through `regs_o`. This exposes address decode slips and bit-order faults. Bank 2 is swept entry by entry. Banks 0 and 1 are sampled at a stride plus their last entry, over both read paths. This separates bank selection from entry indexing, and also shows whether a short bank aliases high indices.

Out-of-range entries and the unused bank code are written and then read back as zero, with neighbouring entries checked to confirm they were not touched. Frames cut short at 20 and 31 bits must leave their target register unchanged. A 34-bit frame must store only the first data word. A register write with the don't-care command bits set must still hit the right register.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int unsigned DW         = 16;
  localparam int unsigned INSTR_BITS = 16;
  localparam int unsigned FRAME_BITS = INSTR_BITS + DW;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned RADDR_W    = 5;
  localparam int unsigned BSEL_W     = 2;
  localparam int unsigned MADDR_W    = 8;

  typedef struct packed {
    logic               rd;
    logic               mem;
    logic [BSEL_W-1:0]  bank;
    logic [MADDR_W-1:0] maddr;
    logic [RADDR_W-1:0] raddr;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [INSTR_BITS-1:0] w);
    cmd_t c;
    c.rd    = w[15];
    c.mem   = w[14];
    c.bank  = w[9:8];
    c.maddr = w[7:0];
    c.raddr = w[4:0];
    return c;
  endfunction
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int unsigned      STAGES  = 2,
  parameter int unsigned      WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else             st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_ctrl_frame.sv
module spi_ctrl_frame
  import spi_ctrl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_s_i,
  input  logic                  cs_s_i,     // synchronised, active low
  input  logic                  mosi_s_i,
  input  logic [DW-1:0]         rd_data_i,
  output logic [INSTR_BITS-1:0] cmd_o,
  output logic                  done_o,     // one pulse per complete frame
  output logic [DW-1:0]         wdata_o,
  output logic                  sck_fall_o,
  output logic [CNT_W-1:0]      bit_cnt_o,
  output logic                  miso_o,
  output logic                  miso_oe_o
);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(INSTR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic                  sck_d_q;
  logic                  sck_rise, sck_fall;
  logic [CNT_W-1:0]      cnt_q;
  logic [DW-1:0]         sh_q, sh_nxt;
  logic [INSTR_BITS-1:0] cmd_q;
  logic                  ld_q, done_q, miso_q;
  logic [DW-1:0]         tx_q, wdata_q;

  assign sck_rise = sck_s_i & ~sck_d_q;
  assign sck_fall = ~sck_s_i & sck_d_q;
  assign sh_nxt   = {sh_q[DW-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      cmd_q   <= '0;
      ld_q    <= 1'b0;
      done_q  <= 1'b0;
      wdata_q <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
    end else begin
      ld_q   <= 1'b0;
      done_q <= 1'b0;
      if (cs_s_i) begin
        cnt_q  <= '0;
        miso_q <= 1'b0;
      end else begin
        // edges past the last bit are ignored until deselect
        if (sck_rise && cnt_q != CNT_FULL) begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_CMD - 1'b1) begin
            cmd_q <= sh_nxt;
            ld_q  <= 1'b1;
          end
          if (cnt_q == CNT_FULL - 1'b1) begin
            done_q  <= 1'b1;
            wdata_q <= sh_nxt;
          end
        end
        if (ld_q) begin
          tx_q <= rd_data_i;
        end else if (sck_fall && cnt_q >= CNT_CMD) begin
          miso_q <= tx_q[DW-1];
          tx_q   <= {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign done_o     = done_q;
  assign wdata_o    = wdata_q;
  assign sck_fall_o = sck_fall;
  assign bit_cnt_o  = cnt_q;
  assign miso_o     = miso_q;
  assign miso_oe_o  = ~cs_s_i;
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [RADDR_W-1:0]     addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic [DW-1:0] rf_q [NUM_REGS];
  logic          in_range;

  assign in_range = 32'(addr_i) < NUM_REGS;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  rf_q[i] <= '0;
      else if (we_i && 32'(addr_i) == 32'(i))       rf_q[i] <= wdata_i;
    end
    assign regs_o[i*DW +: DW] = rf_q[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (in_range && 32'(addr_i) == 32'(i)) rdata_o = rf_q[i];
  end
endmodule

// File: rtl/spi_ctrl_banks.sv
module spi_ctrl_banks
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned DEPTH0    = 128,
  parameter int unsigned DEPTH1    = 128,
  parameter int unsigned DEPTH2    = 64
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [BSEL_W-1:0]  bank_i,
  input  logic [MADDR_W-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [BSEL_W-1:0]  c_bank_i,
  input  logic [MADDR_W-1:0] c_addr_i,
  output logic [DW-1:0]      c_data_o
);
  logic [DW-1:0] rd_b [NUM_BANKS];
  logic [DW-1:0] cd_b [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned D  = (b == 0) ? DEPTH0 : (b == 1) ? DEPTH1 : DEPTH2;
    localparam int unsigned AW = (D > 1) ? $clog2(D) : 1;
    logic [DW-1:0] mem_q [D];
    logic          w_hit;

    assign w_hit = we_i && 32'(bank_i) == 32'(b) && 32'(addr_i) < D;

    always_ff @(posedge clk_i) begin
      if (w_hit) mem_q[addr_i[AW-1:0]] <= wdata_i;
    end

    assign rd_b[b] = (32'(addr_i)   < D) ? mem_q[addr_i[AW-1:0]]   : '0;
    assign cd_b[b] = (32'(c_addr_i) < D) ? mem_q[c_addr_i[AW-1:0]] : '0;
  end

  always_comb begin
    rdata_o  = '0;
    c_data_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (32'(bank_i)   == 32'(b)) rdata_o  = rd_b[b];
      if (32'(c_bank_i) == 32'(b)) c_data_o = cd_b[b];
    end
  end
endmodule

// File: rtl/spi_ctrl_slave.sv
module spi_ctrl_slave
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 32,
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned DEPTH0      = 128,
  parameter int unsigned DEPTH1      = 128,
  parameter int unsigned DEPTH2      = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic                   cs_ni,
  input  logic                   mosi_i,
  output logic                   miso_o,
  output logic                   miso_oe_o,
  input  logic [BSEL_W-1:0]      coef_bank_i,
  input  logic [MADDR_W-1:0]     coef_addr_i,
  output logic [DW-1:0]          coef_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic                  sck_s, cs_s, mosi_s;
  logic [INSTR_BITS-1:0] cmd_w;
  cmd_t                  cmd;
  logic                  frame_done, wr_stb, sck_fall;
  logic [DW-1:0]         wdata, rd_data, reg_rdata, bank_rdata;
  logic [CNT_W-1:0]      bit_cnt;

  spi_ctrl_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, mosi_i}),
    .q_o   ({sck_s, cs_s, mosi_s})
  );

  spi_ctrl_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .cs_s_i    (cs_s),
    .mosi_s_i  (mosi_s),
    .rd_data_i (rd_data),
    .cmd_o     (cmd_w),
    .done_o    (frame_done),
    .wdata_o   (wdata),
    .sck_fall_o(sck_fall),
    .bit_cnt_o (bit_cnt),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
  );

  assign cmd     = cmd_decode(cmd_w);
  assign wr_stb  = frame_done & ~cmd.rd;
  assign rd_data = cmd.mem ? bank_rdata : reg_rdata;

  spi_ctrl_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_stb & ~cmd.mem),
    .addr_i (cmd.raddr),
    .wdata_i(wdata),
    .rdata_o(reg_rdata),
    .regs_o (regs_o)
  );

  spi_ctrl_banks #(
    .NUM_BANKS(NUM_BANKS),
    .DEPTH0   (DEPTH0),
    .DEPTH1   (DEPTH1),
    .DEPTH2   (DEPTH2)
  ) u_banks (
    .clk_i   (clk_i),
    .we_i    (wr_stb & cmd.mem),
    .bank_i  (cmd.bank),
    .addr_i  (cmd.maddr),
    .wdata_i (wdata),
    .rdata_o (bank_rdata),
    .c_bank_i(coef_bank_i),
    .c_addr_i(coef_addr_i),
    .c_data_o(coef_data_o)
  );
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk
  import spi_ctrl_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_s,
  input logic                   sck_fall,
  input logic                   wr_stb,
  input logic                   wr_mem,
  input logic [RADDR_W-1:0]     wr_raddr,
  input logic [DW-1:0]          wr_data,
  input logic [CNT_W-1:0]       bit_cnt,
  input logic                   miso_o,
  input logic [NUM_REGS*DW-1:0] regs_o
);
  AST_IDLE_MISO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !miso_o); // R9

  AST_MISO_ONLY_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_s) |=> $stable(miso_o)); // R4

  AST_WRITE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> !cs_s); // R8

  AST_WRITE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !wr_stb); // R11

  AST_BIT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(bit_cnt) <= FRAME_BITS); // R2

  AST_REG_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && !wr_mem && 32'(wr_raddr) < NUM_REGS)
      |=> regs_o[int'($past(wr_raddr))*DW +: DW] == $past(wr_data)); // R3
endmodule

bind spi_ctrl_slave spi_ctrl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .sck_fall(sck_fall),
  .wr_stb  (wr_stb),
  .wr_mem  (cmd.mem),
  .wr_raddr(cmd.raddr),
  .wr_data (wdata),
  .bit_cnt (bit_cnt),
  .miso_o  (miso_o),
  .regs_o  (regs_o)
);

// File: tb/tb_spi_ctrl_slave.sv
module tb_spi_ctrl_slave;
  localparam int NR   = 32;
  localparam int HALF = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic           miso, miso_oe;
  logic [1:0]     cbank = '0;
  logic [7:0]     caddr = '0;
  logic [15:0]    cdata;
  logic [NR*16-1:0] regs;
  int             total = 0, bad = 0;
  bit             done = 1'b0;

  always #10 clk = ~clk;

  spi_ctrl_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .coef_bank_i(cbank),
    .coef_addr_i(caddr), .coef_data_o(cdata), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_val(input int a);
    return 16'h1234 ^ 16'(a * 16'h0931);
  endfunction

  function automatic logic [15:0] mem_val(input int b, input int a);
    return 16'(b * 16'h4000 + a * 16'h0107 + 16'h005A);
  endfunction

  function automatic logic [15:0] ins_reg(input bit rd, input int a);
    return {rd, 1'b0, 9'b0, 5'(a)};
  endfunction

  function automatic logic [15:0] ins_mem(input bit rd, input int b, input int a);
    return {rd, 1'b1, 4'b0, 2'(b), 8'(a)};
  endfunction

  // host side: drive on low phase, sample miso just before each rising edge
  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? tx[31-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      rx = {rx[30:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] reg_at(input int a);
    return regs[a*16 +: 16];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(regs == '0, "R1 regs zero", 32'(regs[31:0]), 0);
    chk(!miso && !miso_oe, "R1 miso idle", {miso, miso_oe}, 0);

    // R3: register sweep, visible on regs_o
    for (int a = 0; a < NR; a++) xfer({ins_reg(0, a), reg_val(a)}, 32, rx);
    for (int a = 0; a < NR; a++)
      chk(reg_at(a) == reg_val(a), "R3 reg write", reg_at(a), reg_val(a));
    // R4 R9 R2: register read-back over MISO, command half silent
    for (int a = 0; a < NR; a++) begin
      xfer({ins_reg(1, a), 16'hFFFF}, 32, rx);
      chk(rx[15:0] == reg_val(a), "R4 reg read", rx[15:0], reg_val(a));
      chk(rx[31:16] == 0, "R9 cmd half low", rx[31:16], 0);
    end
    chk(regs[7*16 +: 16] == reg_val(7), "R2 read leaves reg", reg_at(7), reg_val(7));

    // R3 don't-care bits 13:5 set on a register write to reg 3
    xfer({16'h3FE3, 16'hBEEF}, 32, rx);
    chk(reg_at(3) == 16'hBEEF, "R3 dont care bits", reg_at(3), 16'hBEEF);

    // R5 R6 R10: bank 2 fully, banks 0/1 strided plus last entry
    for (int a = 0; a < 64; a++) xfer({ins_mem(0, 2, a), mem_val(2, a)}, 32, rx);
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 128; a += 8) xfer({ins_mem(0, b, a), mem_val(b, a)}, 32, rx);
      xfer({ins_mem(0, b, 127), mem_val(b, 127)}, 32, rx);
    end
    for (int a = 0; a < 64; a++) begin
      xfer({ins_mem(1, 2, a), 16'h0000}, 32, rx);
      chk(rx[15:0] == mem_val(2, a), "R6 bank2 read", rx[15:0], mem_val(2, a));
      cbank = 2'd2; caddr = 8'(a);
      @(negedge clk);
      chk(cdata == mem_val(2, a), "R10 bank2 port", cdata, mem_val(2, a));
    end
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 136; a += 8) begin
        int e;
        e = (a > 127) ? 127 : a;
        xfer({ins_mem(1, b, e), 16'h0000}, 32, rx);
        chk(rx[15:0] == mem_val(b, e), "R5 bank write/read", rx[15:0], mem_val(b, e));
        cbank = 2'(b); caddr = 8'(e);
        @(negedge clk);
        chk(cdata == mem_val(b, e), "R10 bank port", cdata, mem_val(b, e));
      end
    end

    // R7 out of range in bank 2 and unused bank 3
    xfer({ins_mem(0, 2, 64), 16'hDEAD}, 32, rx);
    xfer({ins_mem(1, 2, 64), 16'h0000}, 32, rx);
    chk(rx[15:0] == 0, "R7 oor read zero", rx[15:0], 0);
    xfer({ins_mem(1, 2, 0), 16'h0000}, 32, rx);
    chk(rx[15:0] == mem_val(2, 0), "R7 no alias", rx[15:0], mem_val(2, 0));
    xfer({ins_mem(0, 3, 8), 16'hCAFE}, 32, rx);
    xfer({ins_mem(1, 3, 8), 16'h0000}, 32, rx);
    chk(rx[15:0] == 0, "R7 bank3 read zero", rx[15:0], 0);
    for (int b = 0; b < 2; b++) begin
      xfer({ins_mem(1, b, 8), 16'h0000}, 32, rx);
      chk(rx[15:0] == mem_val(b, 8), "R7 bank3 no write", rx[15:0], mem_val(b, 8));
    end
    cbank = 2'd3; caddr = 8'd8;
    @(negedge clk);
    chk(cdata == 0, "R10 bank3 port zero", cdata, 0);
    cbank = 2'd2; caddr = 8'd100;
    @(negedge clk);
    chk(cdata == 0, "R10 oor port zero", cdata, 0);

    // R8 short frames
    keep = reg_at(7);
    xfer({ins_reg(0, 7), 16'h5555}, 20, rx);
    chk(reg_at(7) == keep, "R8 short 20", reg_at(7), keep);
    xfer({ins_reg(0, 7), 16'h5555}, 31, rx);
    chk(reg_at(7) == keep, "R8 short 31", reg_at(7), keep);

    // R11 extra clocks after 32 ignored
    xfer({ins_reg(0, 9), 16'h0F0F}, 34, rx);
    chk(reg_at(9) == 16'h0F0F, "R11 extra clocks", reg_at(9), 16'h0F0F);
    chk(!miso && !miso_oe, "R9 idle after frame", {miso, miso_oe}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule